// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block collects interrupt events from on-chip sources and stores each one in host memory as a 16-byte record of four 32-bit words. The records go into a circular buffer. The buffer's base address and size are set through a small configuration write port. Each record word goes out on its own write request, and the block waits for an acknowledge before it sends the next one. Once the fourth word of a record is acknowledged, the block advances its byte-granular write pointer by 16, wrapping it at the ring size. If writeback is enabled, it then writes a copy of the write-pointer word to a separate memory location, so the host can poll memory instead of a register.

The host consumes records and reports progress by moving the read pointer. It can do this through a configuration write or through a doorbell write that carries a matching index; which path is live depends on a doorbell enable bit. While unread records exist and both enable bits are set, the block holds a level interrupt high. It also emits a one-cycle notification pulse after each stored record. When re-arm mode is on, it emits the same pulse after a read-pointer move that still leaves records unread.

When a record would catch up with the read pointer, the block raises a sticky overflow flag in bit 31 of the write-pointer word and keeps writing, overwriting old records. Software clears the flag with a write-one bit in the control word.

Top module: `ivr_writer`

## Requirements
- R1: After reset, `mem_req`, `irq_level` and `irq_pulse` are 0, `ev_ready` is 1, and `wptr_word` and `rptr_val` are 0.
- R2: An accepted event produces four memory writes in order, at addresses (BASE<<8)+wptr+0, +4, +8 and +12, where BASE is the 32-bit value at configuration address 1. The words are: word0 = {24'b0, src_id}; word1 = {4'b0, src_data[27:0]}; word2 = {pasid[15:0], vmid[7:0], ring_id[7:0]}; word3 = 0.
- R3: If the writeback bit (control bit 2) is set, a fifth write follows the record. It goes to the 40-bit address {configuration address 3 bits [7:0], configuration address 2}, and its data is the updated `wptr_word`.
- R4: The write pointer then becomes (wptr+16) AND mask. Here mask = 2^(S+2)-1, and S is control bits [12:8] clamped to the range 2..MAX_LG, giving the ring size in dwords as 2^S.
- R5: A read-pointer write at configuration address 4 takes effect only while the doorbell is disabled. While it is enabled (address 6 bit 31), only a doorbell whose `db_index` equals address 6 bits [DBI_W-1:0] moves the read pointer. All other doorbells are ignored. The new value is ANDed with mask and with ~15.
- R6: When a record commits while ((wptr+16) AND mask) equals the read pointer, bit 31 of `wptr_word` is set and stays set. The record is still written and the pointer still advances.
- R7: Writing control address 0 with bit 4 = 1 clears the overflow flag.
- R8: `irq_level` = ring enable (control bit 0) AND interrupt enable (control bit 1) AND (wptr != rptr OR overflow).
- R9: While `mem_req` is high without `mem_ack`, `mem_req`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R10: `ev_ready` is low while a write sequence is in progress. An event accepted while ring enable or interrupt enable is 0 is discarded: no memory write happens and the pointer does not change.
- R11: While both enables are set, `irq_pulse` is high for one cycle after each record commits. If re-arm (control bit 3) is also set, it is high for one cycle after a read-pointer update whose new value differs from wptr. Without re-arm, a read-pointer update raises no pulse.
- R12: A write to configuration address 5 sets the write pointer to the written value ANDed with mask and ~15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0 control, 1 base, 2 writeback low, 3 writeback high, 4 read ptr, 5 write ptr, 6 doorbell) |
| cfg_wdata | input | 32 | Configuration write data |
| db_valid | input | 1 | Doorbell write strobe |
| db_index | input | DBI_W | Doorbell index |
| db_data | input | PTR_W | Doorbell read-pointer value in bytes |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event accepted this cycle when high with ev_valid |
| ev_src_id | input | 8 | Event source ID |
| ev_src_data | input | 28 | Event source data |
| ev_ring_id | input | 8 | Event ring ID |
| ev_vmid | input | 8 | Event virtual machine ID |
| ev_pasid | input | 16 | Event process address space ID |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory write accepted |
| irq_level | output | 1 | Level interrupt: records pending |
| irq_pulse | output | 1 | One-cycle notification pulse |
| wptr_word | output | 32 | Write pointer in bytes with overflow flag in bit 31 |
| rptr_val | output | PTR_W | Read pointer in bytes |

## Verification
The assertions assume the memory side behaves as a normal handshake: `mem_ack` is raised only while `mem_req` is high, and every request is eventually acknowledged. The bench's memory model answers only when a request is present. Sometimes it answers at once and sometimes after a one-cycle stall.

The assertions also assume that a software write-pointer write never lands in the same cycle as a record commit, and that the read pointer does not move while a record is in flight. The stimulus keeps to both. It changes pointers and configuration only after the expected-write queue has drained and `ev_ready` has returned high.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

  localparam int ADDR_W  = 40;
  localparam int OVF_BIT = 31;

  typedef enum logic [2:0] {
    CFG_CTRL     = 3'd0,
    CFG_BASE     = 3'd1,
    CFG_WB_LO    = 3'd2,
    CFG_WB_HI    = 3'd3,
    CFG_RPTR     = 3'd4,
    CFG_WPTR     = 3'd5,
    CFG_DOORBELL = 3'd6
  } cfg_addr_e;

  typedef struct packed {
    logic [7:0]  src_id;
    logic [27:0] src_data;
    logic [7:0]  ring_id;
    logic [7:0]  vmid;
    logic [15:0] pasid;
  } ivr_event_t;

  // byte mask of the ring for a log2(dwords) field, clamped to 2..max_lg
  function automatic logic [31:0] ring_mask(input logic [4:0] lg, input int max_lg);
    int c;
    c = int'(lg);
    if (c < 2) c = 2;
    if (c > max_lg) c = max_lg;
    return (32'd1 << (c + 2)) - 32'd1;
  endfunction

  // one dword of the 16-byte record
  function automatic logic [31:0] vec_word(input ivr_event_t e, input logic [1:0] idx);
    case (idx)
      2'd0:    return {24'd0, e.src_id};
      2'd1:    return {4'd0, e.src_data};
      2'd2:    return {e.pasid, e.vmid, e.ring_id};
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/ivr_cfg_regs.sv
module ivr_cfg_regs
  import ivr_pkg::*;
#(
  parameter int DBI_W = 10,
  parameter int PTR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              ring_en,
  output logic              int_en,
  output logic              wb_en,
  output logic              rearm,
  output logic [4:0]        size_lg,
  output logic [31:0]       base,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              db_en,
  output logic [DBI_W-1:0]  db_idx,
  output logic              sw_rptr_we,
  output logic              sw_wptr_we,
  output logic              ovf_clr,
  output logic [PTR_W-1:0]  sw_ptr_val
);

  logic wr_ctrl;

  assign wr_ctrl    = cfg_we && (cfg_addr == CFG_CTRL);
  assign sw_rptr_we = cfg_we && (cfg_addr == CFG_RPTR);
  assign sw_wptr_we = cfg_we && (cfg_addr == CFG_WPTR);
  assign ovf_clr    = wr_ctrl && cfg_wdata[4];
  assign sw_ptr_val = cfg_wdata[PTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_en <= 1'b0;
      int_en  <= 1'b0;
      wb_en   <= 1'b0;
      rearm   <= 1'b0;
      size_lg <= 5'd2;
      base    <= '0;
      wb_addr <= '0;
      db_en   <= 1'b0;
      db_idx  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_CTRL: begin
          ring_en <= cfg_wdata[0];
          int_en  <= cfg_wdata[1];
          wb_en   <= cfg_wdata[2];
          rearm   <= cfg_wdata[3];
          size_lg <= cfg_wdata[12:8];
        end
        CFG_BASE:  base <= cfg_wdata;
        CFG_WB_LO: wb_addr[31:0] <= cfg_wdata;
        CFG_WB_HI: wb_addr[ADDR_W-1:32] <= cfg_wdata[ADDR_W-33:0];
        CFG_DOORBELL: begin
          db_en  <= cfg_wdata[31];
          db_idx <= cfg_wdata[DBI_W-1:0];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ivr_ptr_unit.sv
module ivr_ptr_unit #(
  parameter int PTR_W = 16,
  parameter int DBI_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] mask,
  input  logic             commit,
  input  logic             sw_rptr_we,
  input  logic             sw_wptr_we,
  input  logic [PTR_W-1:0] sw_ptr_val,
  input  logic             db_valid,
  input  logic [DBI_W-1:0] db_index,
  input  logic [PTR_W-1:0] db_data,
  input  logic             db_en,
  input  logic [DBI_W-1:0] db_idx,
  input  logic             ovf_clr,
  input  logic             irq_arm,
  input  logic             rearm,
  output logic [PTR_W-1:0] wptr_q,
  output logic [PTR_W-1:0] rptr_q,
  output logic             ovf_q,
  output logic             full_hit,
  output logic             irq_pulse
);

  localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(15);
  localparam logic [PTR_W-1:0] STEP  = PTR_W'(16);

  logic [PTR_W-1:0] nxt_w;
  logic [PTR_W-1:0] rptr_new;
  logic             db_hit;
  logic             reg_hit;
  logic             rptr_upd;

  assign nxt_w    = (wptr_q + STEP) & mask;
  assign full_hit = (nxt_w == rptr_q);
  assign db_hit   = db_en && db_valid && (db_index == db_idx);
  assign reg_hit  = sw_rptr_we && !db_en;
  assign rptr_upd = db_hit || reg_hit;
  assign rptr_new = (db_hit ? db_data : sw_ptr_val) & mask & ALIGN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q    <= '0;
      rptr_q    <= '0;
      ovf_q     <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      if (sw_wptr_we)  wptr_q <= sw_ptr_val & mask & ALIGN;
      else if (commit) wptr_q <= nxt_w;

      if (rptr_upd) rptr_q <= rptr_new;

      if (commit && full_hit) ovf_q <= 1'b1;
      else if (ovf_clr)       ovf_q <= 1'b0;

      irq_pulse <= irq_arm && (commit || (rptr_upd && rearm && (rptr_new != wptr_q)));
    end
  end

endmodule

// File: rtl/ivr_mem_seq.sv
module ivr_mem_seq
  import ivr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  ivr_event_t        ev_in,
  input  logic              accept_en,
  input  logic              wb_en,
  input  logic [31:0]       base,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [31:0]       wptr_word,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic              mem_ack,
  output logic              ev_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              commit
);

  typedef enum logic [1:0] {S_IDLE, S_VEC, S_WB} seq_state_e;

  seq_state_e state;
  logic [1:0] beat;
  ivr_event_t ev_q;

  assign ev_ready = (state == S_IDLE);
  assign commit   = (state == S_VEC) && mem_ack && (beat == 2'd3);

  always_comb begin
    mem_req   = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_VEC: begin
        mem_req   = 1'b1;
        mem_addr  = {base, 8'h00} + ADDR_W'(wptr) + ADDR_W'({beat, 2'b00});
        mem_wdata = vec_word(ev_q, beat);
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_addr  = wb_addr;
        mem_wdata = wptr_word;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      beat  <= 2'd0;
      ev_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (ev_valid && accept_en) begin
          ev_q  <= ev_in;
          beat  <= 2'd0;
          state <= S_VEC;
        end
        S_VEC: if (mem_ack) begin
          if (beat == 2'd3) state <= wb_en ? S_WB : S_IDLE;
          beat <= beat + 2'd1;
        end
        S_WB: if (mem_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ivr_writer.sv
module ivr_writer
  import ivr_pkg::*;
#(
  parameter int MAX_LG = 14,
  parameter int DBI_W  = 10,
  localparam int PTR_W = MAX_LG + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              db_valid,
  input  logic [DBI_W-1:0]  db_index,
  input  logic [PTR_W-1:0]  db_data,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [7:0]        ev_src_id,
  input  logic [27:0]       ev_src_data,
  input  logic [7:0]        ev_ring_id,
  input  logic [7:0]        ev_vmid,
  input  logic [15:0]       ev_pasid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  output logic              irq_level,
  output logic              irq_pulse,
  output logic [31:0]       wptr_word,
  output logic [PTR_W-1:0]  rptr_val
);

  logic              ring_en, int_en, wb_en, rearm, db_en;
  logic [4:0]        size_lg;
  logic [31:0]       base;
  logic [ADDR_W-1:0] wb_addr;
  logic [DBI_W-1:0]  db_idx;
  logic              sw_rptr_we, sw_wptr_we, ovf_clr;
  logic [PTR_W-1:0]  sw_ptr_val;
  logic [PTR_W-1:0]  mask;
  logic [31:0]       mask_full;
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic              ovf_q, full_hit, commit;
  ivr_event_t        ev_in;

  assign mask_full = ring_mask(size_lg, MAX_LG);
  assign mask      = mask_full[PTR_W-1:0];
  assign ev_in     = '{src_id: ev_src_id, src_data: ev_src_data, ring_id: ev_ring_id,
                       vmid: ev_vmid, pasid: ev_pasid};
  assign wptr_word = {ovf_q, {(31-PTR_W){1'b0}}, wptr_q};
  assign rptr_val  = rptr_q;
  assign irq_level = ring_en && int_en && ((wptr_q != rptr_q) || ovf_q);

  ivr_cfg_regs #(.DBI_W(DBI_W), .PTR_W(PTR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ring_en(ring_en), .int_en(int_en), .wb_en(wb_en), .rearm(rearm), .size_lg(size_lg),
    .base(base), .wb_addr(wb_addr), .db_en(db_en), .db_idx(db_idx),
    .sw_rptr_we(sw_rptr_we), .sw_wptr_we(sw_wptr_we), .ovf_clr(ovf_clr),
    .sw_ptr_val(sw_ptr_val)
  );

  ivr_ptr_unit #(.PTR_W(PTR_W), .DBI_W(DBI_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .mask(mask), .commit(commit),
    .sw_rptr_we(sw_rptr_we), .sw_wptr_we(sw_wptr_we), .sw_ptr_val(sw_ptr_val),
    .db_valid(db_valid), .db_index(db_index), .db_data(db_data),
    .db_en(db_en), .db_idx(db_idx), .ovf_clr(ovf_clr),
    .irq_arm(ring_en && int_en), .rearm(rearm),
    .wptr_q(wptr_q), .rptr_q(rptr_q), .ovf_q(ovf_q), .full_hit(full_hit),
    .irq_pulse(irq_pulse)
  );

  ivr_mem_seq #(.PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_in(ev_in),
    .accept_en(ring_en && int_en), .wb_en(wb_en), .base(base), .wptr(wptr_q),
    .wptr_word(wptr_word), .wb_addr(wb_addr), .mem_ack(mem_ack),
    .ev_ready(ev_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .commit(commit)
  );

endmodule

// File: rtl/ivr_checker.sv
module ivr_checker #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [39:0]      mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             ev_ready,
  input logic             irq_level,
  input logic             ring_en,
  input logic             int_en,
  input logic             commit,
  input logic             sw_wptr_we,
  input logic [PTR_W-1:0] wptr_q,
  input logic             full_hit,
  input logic             ovf_q
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  // R10
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ev_ready);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level |-> ring_en && int_en);

  // R4
  wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !sw_wptr_we |=> $stable(wptr_q));

  // R4
  wptr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_q[3:0] == 4'd0);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && full_hit |=> ovf_q);

endmodule

bind ivr_writer ivr_checker #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ev_ready(ev_ready),
  .irq_level(irq_level), .ring_en(ring_en), .int_en(int_en), .commit(commit),
  .sw_wptr_we(sw_wptr_we), .wptr_q(wptr_q), .full_hit(full_hit), .ovf_q(ovf_q)
);

// File: tb/sim_ivr_writer.sv
module sim_ivr_writer;

  localparam int MAX_LG = 14;
  localparam int DBI_W  = 10;
  localparam int PTR_W  = MAX_LG + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              db_valid = 1'b0;
  logic [DBI_W-1:0]  db_index = '0;
  logic [PTR_W-1:0]  db_data = '0;
  logic              ev_valid = 1'b0;
  logic              ev_ready;
  logic [7:0]        ev_src_id = '0;
  logic [27:0]       ev_src_data = '0;
  logic [7:0]        ev_ring_id = '0;
  logic [7:0]        ev_vmid = '0;
  logic [15:0]       ev_pasid = '0;
  logic              mem_req;
  logic [39:0]       mem_addr;
  logic [31:0]       mem_wdata;
  logic              mem_ack = 1'b0;
  logic              irq_level, irq_pulse;
  logic [31:0]       wptr_word;
  logic [PTR_W-1:0]  rptr_val;

  always #4 clk = ~clk;

  ivr_writer #(.MAX_LG(MAX_LG), .DBI_W(DBI_W)) u0 (.*);

  typedef struct { logic [39:0] a; logic [31:0] d; bit wb; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_fail = 0, pcnt = 0;
  bit stall = 0, tog = 0;

  // bench-side model of the configuration and pointers
  int unsigned m_sz = 2, m_wptr = 0, m_rptr = 0;
  bit m_en = 0, m_ien = 0, m_wb = 0, m_ovf = 0;
  logic [31:0] m_base = 0;
  logic [39:0] m_wba = 0;

  function automatic int unsigned bmask();
    return (32'd4 << m_sz) - 1;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) mem_ack = 1'b0;
    else if (mem_req) begin
      if (stall && !tog) begin
        tog = 1; mem_ack = 1'b0;
      end else begin
        tog = 0; mem_ack = 1'b1;
        if (exp_q.size() == 0) chk("R10 unexpected write", {24'd0, mem_addr}, 64'd0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.wb ? "R3 writeback addr" : "R2 record addr", {24'd0, mem_addr}, {24'd0, e.a});
          chk(e.wb ? "R3 writeback data" : "R2 record data", {32'd0, mem_wdata}, {32'd0, e.d});
        end
      end
    end else mem_ack = 1'b0;
  end

  always @(negedge clk) if (rst_n && irq_pulse) pcnt++;

  task automatic cfg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a == 3'd0) begin
      m_en = d[0]; m_ien = d[1]; m_wb = d[2];
      m_sz = (d[12:8] < 2) ? 2 : (d[12:8] > MAX_LG) ? MAX_LG : int'(d[12:8]);
      if (d[4]) m_ovf = 0;
    end
  endtask

  task automatic ring(input int idx, input int unsigned data);
    @(negedge clk); db_valid = 1; db_index = DBI_W'(idx); db_data = PTR_W'(data);
    @(negedge clk); db_valid = 0;
  endtask

  task automatic send(input logic [7:0] s, input logic [27:0] sd, input logic [7:0] rg,
                      input logic [7:0] vm, input logic [15:0] pa);
    logic [39:0] ba;
    if (m_en && m_ien) begin
      ba = {m_base, 8'h00} + 40'(m_wptr);
      exp_q.push_back('{ba,      {24'd0, s}, 0});
      exp_q.push_back('{ba + 4,  {4'd0, sd}, 0});
      exp_q.push_back('{ba + 8,  {pa, vm, rg}, 0});
      exp_q.push_back('{ba + 12, 32'd0, 0});
      if (((m_wptr + 16) & bmask()) == m_rptr) m_ovf = 1;
      m_wptr = (m_wptr + 16) & bmask();
      if (m_wb) exp_q.push_back('{m_wba, {m_ovf, 31'(m_wptr)}, 1});
    end
    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1; ev_src_id = s; ev_src_data = sd; ev_ring_id = rg; ev_vmid = vm; ev_pasid = pa;
    @(negedge clk); ev_valid = 0;
    while (exp_q.size() != 0 || !ev_ready) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] mw();
    return {32'd0, m_ovf, 31'(m_wptr)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mem_req", {63'd0, mem_req}, 0);
    chk("R1 irq_level", {63'd0, irq_level}, 0);
    chk("R1 ev_ready", {63'd0, ev_ready}, 1);
    chk("R1 wptr_word", {32'd0, wptr_word}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rptr_val", {48'd0, rptr_val}, 0);
    chk("R1 irq_pulse", {63'd0, irq_pulse}, 0);

    m_base = 32'h0001_2345; cfg(3'd1, m_base);
    cfg(3'd2, 32'h0000_8000); cfg(3'd3, 32'h0000_00A5); m_wba = 40'hA5_0000_8000;
    cfg(3'd0, 32'h0000_0407);   // 4-slot ring, writeback on

    // R2 R3 R4 first record, R8 level, R11 pulse
    send(8'h11, 28'hABCDEF1, 8'h22, 8'h33, 16'h4455);
    chk("R4 wptr after one", {32'd0, wptr_word}, mw());
    chk("R8 level pending", {63'd0, irq_level}, 1);
    chk("R11 commit pulse", 64'(pcnt), 1);

    cfg(3'd4, 32'd16); m_rptr = 16;
    chk("R5 rptr reg", {48'd0, rptr_val}, 16);
    chk("R8 level idle", {63'd0, irq_level}, 0);

    // R6 fill and wrap into overflow
    send(8'h01, 28'h0000001, 8'h02, 8'h03, 16'h0004);
    send(8'hFF, 28'hFFFFFFF, 8'hFF, 8'hFF, 16'hFFFF);
    send(8'h5A, 28'h5A5A5A5, 8'hA5, 8'h5A, 16'hA5A5);
    send(8'h77, 28'h1234567, 8'h88, 8'h99, 16'hBEEF);
    chk("R6 overflow set", {32'd0, wptr_word}, 64'h8000_0010);
    chk("R8 level on overflow", {63'd0, irq_level}, 1);
    send(8'h42, 28'h0000042, 8'h00, 8'h01, 16'h0002);
    chk("R6 overflow sticky", {32'd0, wptr_word}, 64'h8000_0020);

    // R7 clear
    cfg(3'd0, 32'h0000_0417);
    chk("R7 overflow cleared", {32'd0, wptr_word}, 64'h0000_0020);
    cfg(3'd4, 32'd32); m_rptr = 32;
    chk("R8 level cleared", {63'd0, irq_level}, 0);

    // R5 doorbell path
    cfg(3'd6, 32'h8000_0005);
    cfg(3'd4, 32'd0);
    chk("R5 reg rptr ignored", {48'd0, rptr_val}, 32);
    send(8'h09, 28'h0000009, 8'h0A, 8'h0B, 16'h000C);
    ring(4, 48);
    chk("R5 wrong doorbell ignored", {48'd0, rptr_val}, 32);
    chk("R8 still pending", {63'd0, irq_level}, 1);
    ring(5, 48 + 7); m_rptr = 48;
    chk("R5 doorbell rptr aligned", {48'd0, rptr_val}, 48);
    chk("R8 idle after doorbell", {63'd0, irq_level}, 0);

    // R11 re-arm
    cfg(3'd0, 32'h0000_040F);
    send(8'h10, 28'h0000010, 8'h10, 8'h10, 16'h0010);
    send(8'h20, 28'h0000020, 8'h20, 8'h20, 16'h0020);
    p0 = pcnt;
    ring(5, 0); m_rptr = 0;
    @(negedge clk);
    chk("R11 rearm pulse", 64'(pcnt), 64'(p0 + 1));
    ring(5, 16); m_rptr = 16;
    @(negedge clk);
    chk("R11 no pulse when empty", 64'(pcnt), 64'(p0 + 1));
    cfg(3'd0, 32'h0000_0407);
    send(8'h30, 28'h0000030, 8'h30, 8'h30, 16'h0030);
    ring(5, 16);
    @(negedge clk);
    chk("R11 no rearm no pulse", 64'(pcnt), 64'(p0 + 2));

    // R10 discard while interrupt enable is off
    p0 = pcnt;
    cfg(3'd0, 32'h0000_0405);
    send(8'hDE, 28'h00000AD, 8'hBE, 8'hEF, 16'hCAFE);
    chk("R10 wptr unchanged", {32'd0, wptr_word}, mw());
    chk("R10 ev_ready back", {63'd0, ev_ready}, 1);
    chk("R8 level gated", {63'd0, irq_level}, 0);
    chk("R11 no pulse when gated", 64'(pcnt), 64'(p0));

    // R12 pointer reset, large ring, no writeback, stalled memory
    cfg(3'd6, 32'h0);
    cfg(3'd0, 32'h0);
    cfg(3'd5, 32'd0); m_wptr = 0;
    cfg(3'd4, 32'd0); m_rptr = 0;
    chk("R12 wptr reset", {32'd0, wptr_word}, 0);
    cfg(3'd0, 32'h0000_1F03);   // size field above limit clamps
    stall = 1;
    for (int i = 0; i < 6; i++)
      send(8'(i * 37), 28'(i * 12345), 8'(i), 8'(255 - i), 16'(i * 4099));
    chk("R4 wptr large ring", {32'd0, wptr_word}, mw());
    chk("R8 pending large ring", {63'd0, irq_level}, 1);
    cfg(3'd5, 32'h0001_1235); m_wptr = 32'h1235 & bmask() & ~32'd15;
    chk("R12 wptr masked write", {32'd0, wptr_word}, mw());

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule